// File: doc/BRIEF.md
# Folded-Symmetry FIR Filter with Streamed Coefficient Reload

The block is a streaming fixed-point FIR filter with 31 taps whose impulse response is mirror-symmetric. It holds only 16 distinct coefficients, b_0 to b_15, where b_15 is the centre tap and b_k = b_(30-k). Before each multiply, a pre-adder sums the two samples that share a coefficient, so one multiplier serves each pair. Samples are 32-bit signed integers. Coefficients are 32-bit signed values with one integer bit and 31 fractional bits.

Samples enter on a valid/ready stream. Results leave on a second valid/ready stream. Each result is the 68-bit full-precision sum reduced to 64 bits: the four least significant bits are removed with round-half-to-even. A separate coefficient stream, which is always ready, replaces the whole set. The new set takes effect only when the sixteenth word arrives. The stream is meant to be used between data runs.

Top module: `sym_fir_top`

## Requirements
- R1: After reset no result is pending (out_valid_o=0), the sample history is all zero and every coefficient is zero, so results are zero until a coefficient set is loaded.
- R2: For an accepted sample x[n], the result is the sum over k=0..30 of c(k)*x[n-k], where c(k)=b_k for k<16 and c(k)=b_(30-k) otherwise, and x[n-k] counts only samples accepted since reset. The sum wraps at 68 bits.
- R3: With history zero and an input of 16 followed by zeros, the results are b_0..b_15 and then b_14..b_0.
- R4: The sum of a mirrored sample pair is formed at 33 bits, so it never overflows: with every sample -2^31 and every coefficient -2^31, the result is exact.
- R5: The 64-bit result is the 68-bit sum divided by 16 and rounded to nearest. A remainder of exactly half rounds to the even quotient.
- R6: Coefficient words load into a shadow set. The active set changes at the edge that accepts the 16th word. A sample accepted at that same edge, or before it, uses the old set.
- R7: Each accepted sample produces exactly one result, in order. The result is valid on the cycle after the sample is accepted.
- R8: While out_valid_o=1 and out_ready_i=0, in_ready_o is 0, and out_data_o and out_valid_o hold their values.
- R9: The first coefficient word after reset, or after a completed set, is b_0. Each following word is the next index, up to b_15.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Sample valid |
| in_ready_o | output | 1 | Sample accepted when high together with valid |
| in_data_i | input | 32 | Signed input sample |
| out_valid_o | output | 1 | Result valid |
| out_ready_i | input | 1 | Downstream takes the result |
| out_data_o | output | 64 | Signed rounded result |
| coef_valid_i | input | 1 | Coefficient word valid |
| coef_ready_o | output | 1 | Always 1 |
| coef_data_i | input | 32 | Signed coefficient word, b_0 first |

## Verification
A result is due exactly one clock edge after its sample is accepted. A coefficient set applies from the edge after the one that takes its 16th word. The bench keeps a behavioural model that advances once per edge. In the middle of each cycle it compares in_ready_o, out_valid_o and out_data_o with the model, then applies the handshakes that will fire at the next edge. As a result, every comparison falls in the single cycle in which the value is due. Random back-pressure on the output shows that a held result keeps its value until the cycle in which it is taken.

// File: rtl/sym_fir_pkg.sv
package sym_fir_pkg;
  localparam int DATA_W_D = 32;
  localparam int COEF_W_D = 32;
  localparam int TAPS_D   = 31;
  localparam int ACC_W_D  = 68;
  localparam int OUT_W_D  = 64;
endpackage

// File: rtl/fir_delay_line.sv
module fir_delay_line #(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 30
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          shift_i,
  input  logic [DATA_W-1:0]             din_i,
  output logic [DEPTH-1:0][DATA_W-1:0]  taps_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) taps_o <= '0;
    else if (shift_i) taps_o <= {taps_o[DEPTH-2:0], din_i};
  end

  p_shift_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    shift_i |=> taps_o[0] == $past(din_i));
endmodule

// File: rtl/fir_coef_bank.sv
module fir_coef_bank #(
  parameter int COEF_W = 32,
  parameter int UNIQ   = 16
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         wr_i,
  input  logic [COEF_W-1:0]            wdata_i,
  output logic [UNIQ-1:0][COEF_W-1:0]  coef_o
);
  localparam int IDX_W = (UNIQ > 1) ? $clog2(UNIQ) : 1;
  localparam logic [IDX_W-1:0] LAST = IDX_W'(UNIQ-1);

  logic [UNIQ-1:0][COEF_W-1:0] shadow_q, full_set;
  logic [IDX_W-1:0]            idx_q;

  always_comb begin
    full_set        = shadow_q;
    full_set[idx_q] = wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      shadow_q <= '0;
      coef_o   <= '0;
      idx_q    <= '0;
    end else if (wr_i) begin
      shadow_q <= full_set;
      if (idx_q == LAST) begin
        coef_o <= full_set;   // whole set commits at once
        idx_q  <= '0;
      end else begin
        idx_q <= idx_q + 1'b1;
      end
    end
  end

  p_partial_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && idx_q != LAST) |=> $stable(coef_o));
  p_wrap_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && idx_q == LAST) |=> idx_q == '0);
endmodule

// File: rtl/fir_fold_mac.sv
module fir_fold_mac #(
  parameter int DATA_W = 32,
  parameter int COEF_W = 32,
  parameter int TAPS   = 31,
  parameter int ACC_W  = 68
) (
  input  logic [DATA_W-1:0]                        x_i,
  input  logic [TAPS-2:0][DATA_W-1:0]              hist_i,
  input  logic [(TAPS+1)/2-1:0][COEF_W-1:0]        coef_i,
  output logic signed [ACC_W-1:0]                  acc_o
);
  localparam int UNIQ   = (TAPS + 1) / 2;
  localparam int PRE_W  = DATA_W + 1;
  localparam int PROD_W = PRE_W + COEF_W;

  logic [DATA_W-1:0]        win   [TAPS];
  logic signed [PROD_W-1:0] prods [UNIQ];

  assign win[0] = x_i;
  for (genvar k = 1; k < TAPS; k++) begin : g_win
    assign win[k] = hist_i[k-1];
  end

  for (genvar p = 0; p < UNIQ; p++) begin : g_pair
    logic signed [PRE_W-1:0] pre;
    if (p == TAPS - 1 - p) begin : g_ctr
      assign pre = $signed({win[p][DATA_W-1], win[p]});
    end else begin : g_side
      assign pre = $signed({win[p][DATA_W-1], win[p]})
                 + $signed({win[TAPS-1-p][DATA_W-1], win[TAPS-1-p]});
    end
    assign prods[p] = pre * $signed(coef_i[p]);
  end

  always_comb begin
    acc_o = '0;
    for (int p = 0; p < UNIQ; p++) acc_o = acc_o + ACC_W'(prods[p]);
  end
endmodule

// File: rtl/fir_round_even.sv
module fir_round_even #(
  parameter int ACC_W = 68,
  parameter int OUT_W = 64
) (
  input  logic signed [ACC_W-1:0] acc_i,
  output logic [OUT_W-1:0]        res_o
);
  localparam int DROP_W = ACC_W - OUT_W;
  localparam logic [DROP_W-1:0] HALF = DROP_W'(1) << (DROP_W - 1);

  logic [OUT_W-1:0]  floor_q;
  logic [DROP_W-1:0] rem;
  logic              up;

  assign floor_q = acc_i[ACC_W-1:DROP_W];
  assign rem     = acc_i[DROP_W-1:0];
  assign up      = (rem > HALF) || ((rem == HALF) && floor_q[0]);
  assign res_o   = floor_q + OUT_W'(up);
endmodule

// File: rtl/sym_fir_top.sv
module sym_fir_top
  import sym_fir_pkg::*;
#(
  parameter int DATA_W = DATA_W_D,
  parameter int COEF_W = COEF_W_D,
  parameter int TAPS   = TAPS_D,
  parameter int ACC_W  = ACC_W_D,
  parameter int OUT_W  = OUT_W_D
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              in_valid_i,
  output logic              in_ready_o,
  input  logic [DATA_W-1:0] in_data_i,
  output logic              out_valid_o,
  input  logic              out_ready_i,
  output logic [OUT_W-1:0]  out_data_o,
  input  logic              coef_valid_i,
  output logic              coef_ready_o,
  input  logic [COEF_W-1:0] coef_data_i
);
  localparam int UNIQ = (TAPS + 1) / 2;
  localparam int HIST = TAPS - 1;

  logic [HIST-1:0][DATA_W-1:0] hist;
  logic [UNIQ-1:0][COEF_W-1:0] coef;
  logic signed [ACC_W-1:0]     acc;
  logic [OUT_W-1:0]            rounded;
  logic                        accept;

  assign coef_ready_o = 1'b1;
  assign in_ready_o   = !out_valid_o || out_ready_i;
  assign accept       = in_valid_i && in_ready_o;

  fir_delay_line #(.DATA_W(DATA_W), .DEPTH(HIST)) u_dly (
    .clk_i, .rst_ni, .shift_i(accept), .din_i(in_data_i), .taps_o(hist));

  fir_coef_bank #(.COEF_W(COEF_W), .UNIQ(UNIQ)) u_coef (
    .clk_i, .rst_ni, .wr_i(coef_valid_i), .wdata_i(coef_data_i), .coef_o(coef));

  fir_fold_mac #(.DATA_W(DATA_W), .COEF_W(COEF_W), .TAPS(TAPS), .ACC_W(ACC_W)) u_mac (
    .x_i(in_data_i), .hist_i(hist), .coef_i(coef), .acc_o(acc));

  fir_round_even #(.ACC_W(ACC_W), .OUT_W(OUT_W)) u_rnd (.acc_i(acc), .res_o(rounded));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_valid_o <= 1'b0;
      out_data_o  <= '0;
    end else if (accept) begin
      out_valid_o <= 1'b1;
      out_data_o  <= rounded;
    end else if (out_ready_i) begin
      out_valid_o <= 1'b0;
    end
  end

  p_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && !out_ready_i) |=> (out_valid_o && $stable(out_data_o)));
  p_accept_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept |=> out_valid_o);
  p_drain_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!in_valid_i && out_ready_i) |=> !out_valid_o);
endmodule

// File: tb/sym_fir_top_tb.sv
`timescale 1ns/1ps
module sym_fir_top_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0, in_ready;
  logic [31:0] in_data = '0;
  logic        out_valid, out_ready = 1'b1;
  logic [63:0] out_data;
  logic        coef_valid = 1'b0, coef_ready;
  logic [31:0] coef_data = '0;

  int total = 0, bad = 0;
  string cur_req = "R1";
  bit stall_mode = 1'b0;

  longint hist [31];
  longint act [16];
  longint shad [16];
  int     cidx = 0;
  bit     exp_valid = 0;
  logic [63:0] exp_data = '0;
  bit     hold_prev = 0;
  logic [63:0] hold_data;

  always #2 clk = ~clk;

  sym_fir_top u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .in_valid_i(in_valid), .in_ready_o(in_ready), .in_data_i(in_data),
    .out_valid_o(out_valid), .out_ready_i(out_ready), .out_data_o(out_data),
    .coef_valid_i(coef_valid), .coef_ready_o(coef_ready), .coef_data_i(coef_data));

  function automatic logic [63:0] model_out();
    logic signed [71:0] s;
    logic signed [67:0] a;
    logic signed [67:0] q;
    logic [3:0] r;
    s = '0;
    for (int k = 0; k < 31; k++) s = s + 72'(act[(k < 16) ? k : 30 - k] * hist[k]);
    a = s[67:0];
    q = a >>> 4;
    r = a[3:0];
    if (r > 4'd8 || (r == 4'd8 && q[0])) q = q + 68'sd1;
    return q[63:0];
  endfunction

  task automatic chk(input string req, input logic [63:0] act_v, input logic [63:0] exp_v);
    total++;
    if (act_v !== exp_v) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act_v, exp_v);
    end
  endtask

  // Mid-cycle compare, then advance model across the coming edge
  always @(negedge clk) begin
    if (!rst_n) begin
      for (int k = 0; k < 31; k++) hist[k] = 0;
      for (int k = 0; k < 16; k++) begin act[k] = 0; shad[k] = 0; end
      cidx = 0; exp_valid = 0; exp_data = '0; hold_prev = 0;
      chk("R1", 64'(out_valid), 64'(0));
    end else begin
      bit exp_ready;
      exp_ready = !exp_valid || out_ready;
      chk("R8", 64'(in_ready), 64'(exp_ready));
      chk("R7", 64'(out_valid), 64'(exp_valid));
      if (exp_valid) chk(cur_req, out_data, exp_data);
      if (hold_prev) chk("R8", out_data, hold_data);
      hold_prev = out_valid && !out_ready;
      hold_data = out_data;
      if (in_valid && exp_ready) begin
        for (int k = 30; k > 0; k--) hist[k] = hist[k-1];
        hist[0] = longint'($signed(in_data));
        exp_data = model_out();
        exp_valid = 1;
      end else if (exp_valid && out_ready) begin
        exp_valid = 0;
      end
      if (coef_valid) begin
        shad[cidx] = longint'($signed(coef_data));
        if (cidx == 15) begin
          for (int k = 0; k < 16; k++) act[k] = shad[k];
          cidx = 0;
        end else cidx++;
      end
    end
  end

  always @(posedge clk) begin
    #1;
    out_ready <= stall_mode ? ($urandom % 3 != 0) : 1'b1;
  end

  task automatic send(input logic [31:0] x);
    in_valid = 1'b1; in_data = x;
    do @(negedge clk); while (!in_ready);
    @(posedge clk); #1;
    in_valid = 1'b0;
  endtask

  task automatic send_coef(input logic [31:0] c);
    coef_valid = 1'b1; coef_data = c;
    @(posedge clk); #1;
    coef_valid = 1'b0;
  endtask

  task automatic flush_hist();
    for (int i = 0; i < 30; i++) send(32'd0);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin @(posedge clk); #1; end
  endtask

  initial begin
    int ref_c [16] = '{-51, -662, -190, 510, 12, -719, 238, 945,
                       -671, -1161, 1438, 1341, -3060, -1460, 10287, 17886};
    idle(3);
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); #1;

    // R1: zero coefficients give zero results
    cur_req = "R1";
    send(32'd12345); send(-32'sd777); send(32'h7fffffff);
    flush_hist(); idle(2);

    // R3 / R9: impulse reproduces b_0..b_15, b_14..b_0
    cur_req = "R3_R9";
    for (int i = 0; i < 16; i++) send_coef(32'(ref_c[i]));
    send(32'd16);
    for (int i = 0; i < 31; i++) send(32'd0);
    idle(2);

    // R2 with R8 back-pressure
    cur_req = "R2_R8";
    stall_mode = 1'b1;
    for (int i = 0; i < 60; i++) send(32'($urandom_range(0, 2097151)) - 32'd1048576);
    stall_mode = 1'b0;
    idle(3);

    // R4: extreme pairs
    cur_req = "R4";
    for (int i = 0; i < 16; i++) send_coef(32'h80000000);
    for (int i = 0; i < 33; i++) send(32'h80000000);
    for (int i = 0; i < 5; i++) send(32'h7fffffff);
    idle(2);

    // R6: partial load keeps old set, completion switches
    cur_req = "R6";
    for (int i = 0; i < 10; i++) send_coef(32'(i * 3 + 1));
    for (int i = 0; i < 8; i++) send(32'(i * 1000 - 3000));
    for (int i = 10; i < 16; i++) send_coef(32'(i * 3 + 1));
    for (int i = 0; i < 8; i++) send(32'(i * 999 + 5));
    idle(2);

    // R6: sample at the commit edge uses the old set
    for (int i = 0; i < 15; i++) send_coef(32'd2);
    coef_valid = 1'b1; coef_data = 32'd5; in_valid = 1'b1; in_data = 32'd4000;
    @(posedge clk); #1;
    coef_valid = 1'b0; in_valid = 1'b0;
    send(32'd4000); idle(2);

    // R5: b_0 = 1, rest 0; half-way cases
    cur_req = "R5";
    send_coef(32'd1);
    for (int i = 1; i < 16; i++) send_coef(32'd0);
    flush_hist();
    send(32'd8); send(32'd24); send(-32'sd8); send(-32'sd24);
    send(32'd9); send(32'd7); send(32'd40); send(-32'sd9);
    idle(3);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #200000;
    bad++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule